// File: doc/BRIEF.md
# DAC Lane Composer

This block produces the four bytes that drive a group of four 8-bit DACs on every clock. Each byte (lane) feeds one DAC, and a group of four DACs serves four consecutive pins. A software-loaded 32-bit default register supplies the bytes in the quiet case. A streaming data source can take over any subset of the lanes on clocks when it presents valid data.

Behind the lane selector sits a fixed colour-space conversion pipeline. It always runs on the selected bytes. It applies a signed 3x3 matrix to lanes 0..2 and carries lane 3 through unchanged. When the conversion enable is high, its output replaces all four lanes. That output is the selected data from four clocks earlier. The result is two layers of override: the streamer overrides the register lane by lane, and the converter overrides everything with a delayed, transformed copy of that same selection.

Top module: `dac_lane_compose`

## Requirements
- R1: After reset, with the streamer idle, all four lanes of `dac_o` read zero, whether the converter is enabled or not.
- R2: A clock with `reg_we_i` high loads `reg_wdata_i` into the default register. From the next clock, when the streamer is idle and the converter is off, lane k of `dac_o` (bits 8k+7..8k) equals byte k of the register. Without a write, the register holds its value.
- R3: With the converter off and `strm_valid_i` high, each lane k whose bit k of `strm_lane_mask_i` is 1 outputs byte k of `strm_data_i` in the same clock.
- R4: Lanes whose mask bit is 0, and every lane while `strm_valid_i` is low, keep the register byte. The streamer data and mask have no effect on them.
- R5: With the converter enabled, lane i (i = 0..2) outputs clamp(round((sum over j of c[i][j]*x[j]) / 128)). Here x is the lanes 0..2 selected four clocks earlier, read as unsigned. Rounding adds 64 before an arithmetic shift right by 7. The default signed coefficients are: row 0 = {38, 75, 15}, row 1 = {-22, -42, 64}, row 2 = {100, 60, -32} (columns for x0, x1, x2).
- R6: With the converter enabled, lane 3 outputs the lane 3 byte selected exactly four clocks earlier.
- R7: Converted results below 0 output 0, and results above 255 output 255.
- R8: The converter enable switches the output source in the same clock it changes. The pipeline runs every clock regardless of the enable, so the first outputs after enabling come from data that entered the pipeline while the enable was low.
- R9: With the streamer idle and the converter enabled, the default register value is the converter input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Write strobe for the default register |
| reg_wdata_i | input | 32 | Default register write data, byte k for lane k |
| strm_valid_i | input | 1 | Streamer presents data this clock |
| strm_data_i | input | 32 | Streamer bytes, byte k for lane k |
| strm_lane_mask_i | input | 4 | Lanes the streamer may override |
| csc_en_i | input | 1 | Select the colour-space converter output |
| dac_o | output | 32 | DAC bytes, lane k at bits 8k+7..8k |

## Verification
The bench targets the four-clock latency: a pipeline one stage short or long shows converted values shifted by a clock against the model history. Negative and overflowing matrix sums are driven directly. A clamp that wraps would show large bytes where 0 is due, and small bytes where 255 is due. Enable toggles check that the source switches in the same clock and that the pipeline kept running while disabled. A pipeline that stalls would output stale conversions. Partial lane masks and idle clocks with non-zero streamer data catch a mask applied to the wrong lanes or a mux that ignores the valid flag.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;
  localparam int unsigned CSC_N  = 3;
  localparam int unsigned COEF_W = 8;
  localparam int unsigned FRAC_W = 7;

  typedef logic [LANE_W-1:0]            lane_t;
  typedef logic [LANES-1:0][LANE_W-1:0] word_t;

  // c[i][j] at bits (i*3+j)*8 +: 8
  localparam logic [CSC_N*CSC_N*COEF_W-1:0] CSC_COEF_DEF =
    {8'hE0, 8'h3C, 8'h64, 8'h40, 8'hD6, 8'hEA, 8'h0F, 8'h4B, 8'h26};
endpackage

// File: rtl/dlc_dflt_reg.sv
module dlc_dflt_reg
  import dlc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  word_t wdata_i,
  output word_t q_o
);
  word_t q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= wdata_i;
  end

  assign q_o = q_q;

  AST_REG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i))); // R2
  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o)); // R2
endmodule

// File: rtl/dlc_lane_mux.sv
module dlc_lane_mux
  import dlc_pkg::*;
(
  input  word_t            dflt_i,
  input  logic             strm_valid_i,
  input  word_t            strm_data_i,
  input  logic [LANES-1:0] strm_mask_i,
  output word_t            sel_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign sel_o[k] = (strm_valid_i && strm_mask_i[k]) ? strm_data_i[k] : dflt_i[k];
  end
endmodule

// File: rtl/dlc_csc_pipe.sv
module dlc_csc_pipe
  import dlc_pkg::*;
#(
  parameter logic [CSC_N*CSC_N*COEF_W-1:0] COEFS = CSC_COEF_DEF
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t in_i,
  output word_t out_o
);
  localparam int unsigned PROD_W = COEF_W + LANE_W + 1;
  localparam int unsigned SUM_W  = PROD_W + 2;
  localparam logic signed [SUM_W-1:0] RND = SUM_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << LANE_W) - 1);

  word_t x_q;
  lane_t p3_q, s3_q;
  logic signed [PROD_W-1:0] prod_q [CSC_N][CSC_N];
  logic signed [SUM_W-1:0]  sum_q  [CSC_N];
  word_t y_q;

  // stage 1: capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) x_q <= '0;
    else         x_q <= in_i;
  end

  // stage 2: products
  for (genvar i = 0; i < CSC_N; i++) begin : g_row
    for (genvar j = 0; j < CSC_N; j++) begin : g_col
      localparam logic signed [COEF_W-1:0] C = COEFS[(i*CSC_N+j)*COEF_W +: COEF_W];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prod_q[i][j] <= '0;
        else         prod_q[i][j] <= C * $signed({1'b0, x_q[j]});
      end
    end

    // stage 3: row sum
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_q[i] <= '0;
      else sum_q[i] <= $signed({{2{prod_q[i][0][PROD_W-1]}}, prod_q[i][0]})
                     + $signed({{2{prod_q[i][1][PROD_W-1]}}, prod_q[i][1]})
                     + $signed({{2{prod_q[i][2][PROD_W-1]}}, prod_q[i][2]});
    end

    // stage 4: round and clamp
    logic signed [SUM_W-1:0] rnd;
    lane_t sat;
    always_comb begin
      rnd = (sum_q[i] + RND) >>> FRAC_W;
      if (rnd < 0)         sat = '0;
      else if (rnd > MAXV) sat = '1;
      else                 sat = rnd[LANE_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) y_q[i] <= '0;
      else         y_q[i] <= sat;
    end
  end

  // pass-through lane rides the same four stages
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p3_q <= '0; s3_q <= '0; y_q[LANES-1] <= '0;
    end else begin
      p3_q <= x_q[LANES-1];
      s3_q <= p3_q;
      y_q[LANES-1] <= s3_q;
    end
  end

  assign out_o = y_q;

  // cycles since reset, saturating at pipeline depth
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 3'd4) age_q <= age_q + 3'd1;
  end

  AST_PASS_LANE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'd4) |-> (out_o[LANES-1] == $past(in_i[LANES-1], 4))); // R6
endmodule

// File: rtl/dac_lane_compose.sv
module dac_lane_compose
  import dlc_pkg::*;
#(
  parameter logic [CSC_N*CSC_N*COEF_W-1:0] CSC_COEFS = CSC_COEF_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic              strm_valid_i,
  input  logic [WORD_W-1:0] strm_data_i,
  input  logic [LANES-1:0]  strm_lane_mask_i,
  input  logic              csc_en_i,
  output logic [WORD_W-1:0] dac_o
);
  word_t dflt_q, sel, csc_out;

  dlc_dflt_reg u_dflt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .q_o     (dflt_q)
  );

  dlc_lane_mux u_mux (
    .dflt_i       (dflt_q),
    .strm_valid_i (strm_valid_i),
    .strm_data_i  (strm_data_i),
    .strm_mask_i  (strm_lane_mask_i),
    .sel_o        (sel)
  );

  dlc_csc_pipe #(.COEFS(CSC_COEFS)) u_csc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (sel),
    .out_o  (csc_out)
  );

  assign dac_o = csc_en_i ? csc_out : sel;

  AST_IDLE_USES_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csc_en_i && !strm_valid_i) |-> (dac_o == dflt_q)); // R2
  AST_STRM_LANE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csc_en_i && strm_valid_i && strm_lane_mask_i[0]) |-> (dac_o[7:0] == strm_data_i[7:0])); // R3
  AST_UNMASKED_LANE3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csc_en_i && !strm_lane_mask_i[3]) |-> (dac_o[31:24] == dflt_q[3])); // R4
endmodule

// File: tb/dac_lane_compose_tb_top.sv
module dac_lane_compose_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        strm_valid = 1'b0;
  logic [31:0] strm_data = '0;
  logic [3:0]  strm_mask = '0;
  logic        csc_en = 1'b0;
  logic [31:0] dac;

  int checks = 0;
  int fails = 0;
  logic [31:0] dflt_m = '0;
  logic [31:0] hist [4];
  logic        prev_en = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dac_lane_compose dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .strm_valid_i(strm_valid), .strm_data_i(strm_data), .strm_lane_mask_i(strm_mask),
    .csc_en_i(csc_en), .dac_o(dac)
  );

  function automatic int coef(int i, int j);
    int c [3][3] = '{'{38, 75, 15}, '{-22, -42, 64}, '{100, 60, -32}};
    return c[i][j];
  endfunction

  function automatic logic [31:0] conv(logic [31:0] x);
    logic [31:0] y;
    for (int i = 0; i < 3; i++) begin
      int s = 64;
      for (int j = 0; j < 3; j++) s += coef(i, j) * int'(x[8*j +: 8]);
      s = s >>> 7;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      y[8*i +: 8] = 8'(s);
    end
    y[31:24] = x[31:24];
    return y;
  endfunction

  function automatic logic [31:0] pick(logic [31:0] d, logic v, logic [31:0] s, logic [3:0] m);
    logic [31:0] r = d;
    for (int k = 0; k < 4; k++) if (v && m[k]) r[8*k +: 8] = s[8*k +: 8];
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic we, logic [31:0] wd, logic sv, logic [31:0] sd, logic [3:0] sm, logic en);
    logic [31:0] m, exp;
    string req;
    @(negedge clk);
    reg_we = we; reg_wdata = wd; strm_valid = sv; strm_data = sd; strm_mask = sm; csc_en = en;
    #(CLK_P/4);
    m = pick(dflt_m, sv, sd, sm);
    exp = en ? conv(hist[3]) : m;
    for (int k = 0; k < 4; k++) begin
      if (en != prev_en)  req = "R8";
      else if (en)        req = (k == 3) ? "R6" : "R5";
      else if (!sv)       req = "R2";
      else if (sm[k])     req = "R3";
      else                req = "R4";
      chk(req, dac[8*k +: 8], exp[8*k +: 8]);
    end
    prev_en = en;
    @(posedge clk);
    if (we) dflt_m = wd;
    hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = m;
  endtask

  task automatic peek(string req, logic [31:0] exp);
    #(CLK_P/4);
    for (int k = 0; k < 4; k++) chk(req, dac[8*k +: 8], exp[8*k +: 8]);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) hist[k] = '0;
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    peek("R1", 32'h0);
    @(negedge clk); csc_en = 1'b1; prev_en = 1'b1;
    peek("R1", 32'h0);
    @(negedge clk); csc_en = 1'b0; prev_en = 1'b0;

    // R2 register load, then idle streamer data ignored (R4)
    step(1, 32'hA1B2C3D4, 0, 32'h0, 4'h0, 0);
    step(0, 32'h0, 0, 32'hFFFFFFFF, 4'hF, 0);
    step(0, 32'h0, 1, 32'h11223344, 4'b0101, 0);   // R3 / R4 partial mask
    step(0, 32'h0, 1, 32'h55667788, 4'b1010, 0);

    // R7 saturation with R9 register feeding converter: lanes {0,0,FF,FF}
    step(1, 32'h0000FFFF, 0, 32'h0, 4'h0, 0);
    for (int n = 0; n < 5; n++) step(0, 32'h0, 0, 32'h0, 4'h0, 1);
    peek("R7", {8'h00, 8'hFF, 8'h00, 8'hE1}); // row1 negative->00, row2 319->FF
    step(0, 32'h0, 0, 32'h0, 4'h0, 1);
    peek("R9", conv(32'h0000FFFF));

    // R8: pipeline keeps running while disabled
    step(1, 32'h7F102030, 0, 32'h0, 4'h0, 0);
    step(0, 32'h0, 1, 32'hC0FFEE99, 4'hF, 0);
    step(0, 32'h0, 1, 32'h01020304, 4'h3, 1);
    step(0, 32'h0, 0, 32'h0, 4'h0, 1);
    step(0, 32'h0, 0, 32'h0, 4'h0, 0);

    // random phase
    begin
      logic en_r = 1'b0;
      for (int n = 0; n < 3000; n++) begin
        if ($urandom_range(15) == 0) en_r = ~en_r;
        step($urandom_range(3) == 0, $urandom, $urandom_range(1) == 1, $urandom,
             4'($urandom_range(15)), en_r);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule